// File: doc/BRIEF.md
# Lock-Step Comparator with Built-In Self-Test

This block sits between two copies of a controller, a primary and a redundant diagnostic copy, which receive identical commands. In normal operation it compares their output vectors on every clock cycle and raises a compare error in the cycle after any difference appears. Downstream error-collection logic decides how to respond to that error.

Software selects the operating mode by writing a key to the mode register. One key runs a built-in self-test of the comparator itself. During the test the comparator's two ports are fed from an internal pattern generator instead of the live controller outputs, and the live compare error is held low. The test first checks that identical vectors compare equal. It then checks that every single-bit difference on either port is detected. It ends with a sticky error flag or a sticky completion flag. Two further keys inject faults on purpose: one into the live compare path, and one into the self-test. These prove that each error path works all the way to its output.

Top module: `lsc_top`

## Requirements
- R1: After synchronous reset the block is in lock-step mode, and `cmp_err`, `st_err` and `st_done` are all low.
- R2: In lock-step mode, `cmp_err` is high in the cycle after a clock edge at which `vec_a` differed from `vec_b`, and low after an edge at which they were equal.
- R3: A write (`mode_wr` high at a clock edge) with key 4'hA selects lock-step, 4'h6 selects self-test, 4'h9 selects error-forcing and 4'hF selects self-test-error-forcing. A write with any other key changes neither the mode nor the flags.
- R4: In both self-test modes `cmp_err` stays low from the first edge after the write onward, and the live inputs have no effect on any output.
- R5: The self-test begins with a 4-step match phase. In that phase both ports carry the same vector: all-zeros, then all-ones, then 10'h155, then 10'h2AA. A detected difference in this phase sets `st_err` and ends the test immediately.
- R6: A 20-step mismatch phase follows. Steps 0–9 set only bit 0–9 of port A, and steps 10–19 set only bit 0–9 of port B, with all other bits zero. Any step that compares equal sets `st_err` and ends the test.
- R7: A self-test that finds no fault raises `st_done` after the 24th clock edge following the write edge, and not before. `st_done` and `st_err` are never high together.
- R8: `st_err` and `st_done` hold their values until the next accepted mode write, which clears both of them.
- R9: In error-forcing mode, with equal live inputs, `cmp_err` is high for exactly one cycle, in the cycle after the first edge following the write. After that it again follows live differences as in R2.
- R10: In self-test-error-forcing mode, port B's bit 0 is inverted in the first match step. As a result `st_err` rises after the first edge following the write, and `st_done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_key | input | 4 | Mode key written when `mode_wr` is high |
| vec_a | input | 10 | Output vector of the primary controller |
| vec_b | input | 10 | Output vector of the diagnostic controller |
| cmp_err | output | 1 | Live compare error, registered |
| st_err | output | 1 | Sticky self-test error flag |
| st_done | output | 1 | Sticky self-test completion flag |

## Verification
The embedded assertions check on every cycle that the mode holds without an accepted write, and that `cmp_err` stays low whenever comparison is disabled. They also check that the two self-test flags are exclusive and sticky, and that the step counter never passes the last step. Only the bench scenarios can show the externally visible timing. That covers the exhaustive lock-step sweep, the exact edge on which `st_done` or `st_err` rises, the single forced `cmp_err` pulse, and that invalid keys and live input traffic during self-test leave every output unchanged.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    localparam int VEC_W       = 10;
    localparam int MATCH_STEPS = 4;

    typedef enum logic [3:0] {
        MODE_LOCK     = 4'hA,
        MODE_SELFTEST = 4'h6,
        MODE_ERRFORCE = 4'h9,
        MODE_STFORCE  = 4'hF
    } mode_e;

    typedef struct packed {
        logic cmp_en;    // live comparison reported on cmp_err
        logic use_pat;   // compare ports fed by the pattern generator
        logic st_inject; // corrupt the first match step
    } mode_ctl_t;

    function automatic logic key_ok(input logic [3:0] k);
        return (k == MODE_LOCK) || (k == MODE_SELFTEST) ||
               (k == MODE_ERRFORCE) || (k == MODE_STFORCE);
    endfunction

    function automatic mode_ctl_t decode_mode(input mode_e m);
        mode_ctl_t c;
        c.cmp_en    = (m == MODE_LOCK) || (m == MODE_ERRFORCE);
        c.use_pat   = (m == MODE_SELFTEST) || (m == MODE_STFORCE);
        c.st_inject = (m == MODE_STFORCE);
        return c;
    endfunction

endpackage

// File: rtl/lsc_mode_reg.sv
module lsc_mode_reg
    import lsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [3:0] key,
    output mode_ctl_t  ctl,
    output logic       wr_ok,
    output logic       st_start,
    output logic       inj
);
    mode_e mode_q;

    assign wr_ok    = wr && key_ok(key);
    assign st_start = wr_ok && ((key == MODE_SELFTEST) || (key == MODE_STFORCE));
    assign ctl      = decode_mode(mode_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_LOCK;
            inj    <= 1'b0;
        end else begin
            if (wr_ok) mode_q <= mode_e'(key);
            inj <= wr_ok && (key == MODE_ERRFORCE);
        end
    end

    a_r3_mode_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_ok |=> $stable(mode_q));
    a_r9_inject_once: assert property (@(posedge clk) disable iff (rst)
        inj |=> !inj);
endmodule

// File: rtl/lsc_pattern_gen.sv
module lsc_pattern_gen #(
    parameter int W      = lsc_pkg::VEC_W,
    parameter int STEP_W = 5
) (
    input  logic [STEP_W-1:0] step,
    input  logic              st_inject,
    output logic [W-1:0]      pa,
    output logic [W-1:0]      pb,
    output logic              want_diff
);
    import lsc_pkg::*;

    localparam int MISM_STEPS = 2 * W;

    logic [W-1:0] alt;
    always_comb begin
        for (int i = 0; i < W; i++) alt[i] = (i % 2 == 0);
    end

    always_comb begin
        pa        = '0;
        pb        = '0;
        want_diff = 1'b0;
        if (int'(step) < MATCH_STEPS) begin
            case (step[1:0])
                2'd0:    pa = '0;
                2'd1:    pa = '1;
                2'd2:    pa = alt;
                default: pa = ~alt;
            endcase
            pb = pa;
            if (st_inject && (step == '0)) pb[0] = ~pa[0];
        end else begin
            want_diff = 1'b1;
            for (int i = 0; i < W; i++) begin
                pa[i] = (int'(step) - MATCH_STEPS == i);
                pb[i] = (int'(step) - MATCH_STEPS == i + W);
            end
        end
    end

    a_r6_one_bit: assert final (!want_diff || ($countones({pa, pb}) == 1) ||
                                (int'(step) >= MATCH_STEPS + MISM_STEPS));
endmodule

// File: rtl/lsc_compare.sv
module lsc_compare #(
    parameter int W = lsc_pkg::VEC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         use_pat,
    input  logic         cmp_en,
    input  logic         inj,
    input  logic [W-1:0] live_a,
    input  logic [W-1:0] live_b,
    input  logic [W-1:0] pat_a,
    input  logic [W-1:0] pat_b,
    output logic         diff,
    output logic         cmp_err
);
    logic [W-1:0] port_a, port_b;

    always_comb begin
        port_a = use_pat ? pat_a : live_a;
        port_b = use_pat ? pat_b : live_b;
        if (inj) port_a[0] = ~port_a[0];
    end

    assign diff = (port_a != port_b);

    always_ff @(posedge clk) begin
        if (rst) cmp_err <= 1'b0;
        else     cmp_err <= cmp_en && diff;
    end

    a_r4_quiet: assert property (@(posedge clk) disable iff (rst)
        !cmp_en |=> !cmp_err);
    a_r9_forced: assert property (@(posedge clk) disable iff (rst)
        (inj && cmp_en && !use_pat && (live_a == live_b)) |=> cmp_err);
endmodule

// File: rtl/lsc_sequencer.sv
module lsc_sequencer #(
    parameter int TOTAL  = 24,
    parameter int MATCH  = 4,
    parameter int STEP_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              start,
    input  logic              diff,
    input  logic              want_diff,
    output logic [STEP_W-1:0] step,
    output logic              st_err,
    output logic              st_done
);
    localparam logic [STEP_W-1:0] LAST = STEP_W'(TOTAL - 1);

    logic running;

    always_ff @(posedge clk) begin
        if (rst) begin
            step    <= '0;
            running <= 1'b0;
            st_err  <= 1'b0;
            st_done <= 1'b0;
        end else if (clear) begin
            step    <= '0;
            running <= start;
            st_err  <= 1'b0;
            st_done <= 1'b0;
        end else if (running) begin
            if (diff != want_diff) begin
                st_err  <= 1'b1;
                running <= 1'b0;
            end else if (step == LAST) begin
                st_done <= 1'b1;
                running <= 1'b0;
            end else begin
                step <= step + 1'b1;
            end
        end
    end

    a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(st_err && st_done));
    a_r6_bound: assert property (@(posedge clk) disable iff (rst)
        running |-> (step <= LAST));
    a_r5_stop: assert property (@(posedge clk) disable iff (rst)
        (running && !clear && (int'(step) < MATCH) && diff) |=> (st_err && !running));
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (st_err && !clear) |=> st_err);
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
        (st_done && !clear) |=> st_done);
endmodule

// File: rtl/lsc_top.sv
module lsc_top
    import lsc_pkg::*;
#(
    parameter int W = VEC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mode_wr,
    input  logic [3:0]   mode_key,
    input  logic [W-1:0] vec_a,
    input  logic [W-1:0] vec_b,
    output logic         cmp_err,
    output logic         st_err,
    output logic         st_done
);
    localparam int TOTAL  = MATCH_STEPS + 2 * W;
    localparam int STEP_W = $clog2(TOTAL + 1);

    mode_ctl_t         ctl;
    logic              wr_ok, st_start, inj, diff, want_diff;
    logic [STEP_W-1:0] step;
    logic [W-1:0]      pa, pb;

    lsc_mode_reg u_mode (
        .clk(clk), .rst(rst), .wr(mode_wr), .key(mode_key),
        .ctl(ctl), .wr_ok(wr_ok), .st_start(st_start), .inj(inj)
    );

    lsc_pattern_gen #(.W(W), .STEP_W(STEP_W)) u_pat (
        .step(step), .st_inject(ctl.st_inject),
        .pa(pa), .pb(pb), .want_diff(want_diff)
    );

    lsc_compare #(.W(W)) u_cmp (
        .clk(clk), .rst(rst), .use_pat(ctl.use_pat), .cmp_en(ctl.cmp_en),
        .inj(inj), .live_a(vec_a), .live_b(vec_b), .pat_a(pa), .pat_b(pb),
        .diff(diff), .cmp_err(cmp_err)
    );

    lsc_sequencer #(.TOTAL(TOTAL), .MATCH(MATCH_STEPS), .STEP_W(STEP_W)) u_seq (
        .clk(clk), .rst(rst), .clear(wr_ok), .start(st_start),
        .diff(diff), .want_diff(want_diff),
        .step(step), .st_err(st_err), .st_done(st_done)
    );
endmodule

// File: tb/lsc_top_test.sv
module lsc_top_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_wr = 1'b0;
    logic [3:0] mode_key = 4'h0;
    logic [9:0] vec_a = '0, vec_b = '0;
    logic       cmp_err, st_err, st_done;

    int checks = 0, failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    lsc_top uut (.clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_key(mode_key),
                 .vec_a(vec_a), .vec_b(vec_b),
                 .cmp_err(cmp_err), .st_err(st_err), .st_done(st_done));

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr_mode(input logic [3:0] k);
        mode_wr = 1'b1; mode_key = k;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    // Runs a clean self-test from the call, expecting completion on edge 24.
    task automatic clean_selftest(input string req);
        vec_a = '0; vec_b = '0;
        wr_mode(4'h6);
        vec_a = 10'h3C3; vec_b = 10'h00F;   // live traffic must be ignored (R4)
        for (int n = 1; n <= 23; n++) begin
            @(negedge clk);
            chk({req, " done early"}, st_done, 1'b0);
            chk({req, " err"}, st_err, 1'b0);
            chk("R4 cmp_err quiet", cmp_err, 1'b0);
        end
        @(negedge clk);
        chk({req, " done at step 24"}, st_done, 1'b1);
        chk({req, " err at end"}, st_err, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 cmp_err", cmp_err, 1'b0);
        chk("R1 st_err", st_err, 1'b0);
        chk("R1 st_done", st_done, 1'b0);
        vec_a = 10'h001; vec_b = 10'h000;
        @(negedge clk);
        chk("R1 default lock-step", cmp_err, 1'b1);

        // R2: exhaustive sweep of port A with computed port B
        for (int a = 0; a < 1024; a++) begin
            logic [9:0] av, bv;
            av = 10'(a);
            bv = (a % 3 == 0) ? av : (av ^ 10'(1 << (a % 10)));
            vec_a = av; vec_b = bv;
            @(negedge clk);
            chk("R2 compare", cmp_err, (av != bv));
        end

        // R3: every invalid key leaves lock-step in place
        for (int k = 0; k < 16; k++) begin
            if (k != 'hA && k != 'h6 && k != 'h9 && k != 'hF) begin
                vec_a = '0; vec_b = '0;
                wr_mode(4'(k));
                vec_a = 10'h200; vec_b = 10'h000;
                @(negedge clk);
                chk("R3 invalid key keeps lock-step", cmp_err, 1'b1);
            end
        end

        // R5 R6 R7: clean self-test
        clean_selftest("R7");
        repeat (5) begin
            @(negedge clk);
            chk("R8 done sticky", st_done, 1'b1);
            chk("R4 cmp_err quiet after test", cmp_err, 1'b0);
        end
        // R3 R8: invalid key does not clear the flag
        wr_mode(4'h2);
        @(negedge clk);
        chk("R3 invalid key keeps flags", st_done, 1'b1);
        chk("R4 still quiet", cmp_err, 1'b0);

        // R8 R3: lock-step key clears flags, comparison resumes
        wr_mode(4'hA);
        chk("R8 done cleared by write", st_done, 1'b0);
        chk("R8 err clear", st_err, 1'b0);
        @(negedge clk);
        chk("R3 back to lock-step", cmp_err, 1'b1);

        // R10: forced self-test error
        vec_a = '0; vec_b = '0;
        wr_mode(4'hF);
        chk("R10 err not yet", st_err, 1'b0);
        @(negedge clk);
        chk("R10 err after first step", st_err, 1'b1);
        chk("R10 done low", st_done, 1'b0);
        vec_a = 10'h155; vec_b = 10'h0AA;
        repeat (30) begin
            @(negedge clk);
            chk("R8 err sticky", st_err, 1'b1);
            chk("R10 done never", st_done, 1'b0);
            chk("R4 cmp_err quiet in forced test", cmp_err, 1'b0);
        end

        // R8: restarting the self-test clears the error
        clean_selftest("R8 restart");

        // R9: error-forcing mode
        wr_mode(4'hA);
        vec_a = '0; vec_b = '0;
        @(negedge clk);
        wr_mode(4'h9);
        chk("R9 no pulse on write edge", cmp_err, 1'b0);
        @(negedge clk);
        chk("R9 forced pulse", cmp_err, 1'b1);
        @(negedge clk);
        chk("R9 pulse one cycle", cmp_err, 1'b0);
        vec_a = 10'h010;
        @(negedge clk);
        chk("R9 live mismatch after force", cmp_err, 1'b1);
        vec_a = '0;
        @(negedge clk);
        chk("R9 live match after force", cmp_err, 1'b0);

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule